// File: doc/BRIEF.md
# Dual-Channel Fixed-Frequency Current Chopper

This block is the digital control core for two H-bridges that regulate winding current by peak-current chopping at a fixed frequency. A shared cycle timer starts a new PWM cycle for each channel. At that start, the channel's source latch is set and the bridge drives in the direction chosen by its phase input. Later in the cycle, a synchronized current-trip input clears the latch. The trip is ignored for a blanking window after each cycle start. Once the latch is clear, the winding recirculates through both low-side switches until the cycle ends. The second channel's cycle starts half a period after the first one, so the supply never sees both on-pulses begin together.

Each channel drives four gate-enable outputs: high-side and low-side for leg A and for leg B. A per-leg dead-time stage turns a switch off at once. It turns the opposite switch of the same leg on only after the leg has been fully off for a set number of clock cycles. A shared active-low sleep input forces every output off. So does a shared fault input. A per-channel active-low enable switches off all four switches of its channel, which gives fast decay through the body diodes.

The period is `OVERHEAD_CYC + BLANK_CYC + RC_CYC` clock cycles. Blank time and dead time are parameters.

Top module: `dual_chopper`

## Requirements
- R1: With sleep high, fault low, enable low and no trip, each channel drives in the phase direction. Phase 1 gives gate_ah=1, gate_bl=1, gate_al=0, gate_bh=0. Phase 0 gives gate_bh=1, gate_al=1, gate_ah=0, gate_bl=0.
- R2: The trip input passes through a two-stage synchronizer. A trip seen outside the blanking window clears the source latch. The high-side switch then turns off and both low sides (gate_al=1, gate_bl=1) stay on until the next cycle start.
- R3: For BLANK_CYC cycles after each cycle start, the trip is ignored. With trip held high, the source still turns on in every cycle, and it conducts for no more than BLANK_CYC+1 cycles.
- R4: Consecutive source turn-ons of a channel are exactly OVERHEAD_CYC + BLANK_CYC + RC_CYC clock cycles apart.
- R5: Channel 1's cycle start lags channel 0's by half a period (integer division). Its source turn-on follows channel 0's by the same amount.
- R6: When sleep_n is low, all gate outputs are low in the same cycle, whatever the other inputs are.
- R7: When a channel's en_n is high, all four of that channel's gate outputs are low in the same cycle.
- R8: The high-side and low-side gates of a leg are never high together. Either one turns on only after the other has been low for at least DEAD_CYC cycles.
- R9: When fault is high, all gate outputs are low in the same cycle. After fault clears, no source switch turns on before the next cycle start.
- R10: While rst_n is low, every gate output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep, shared by both channels |
| fault | input | 1 | Fault disable, shared by both channels |
| phase | input | N_CH | Direction per channel (1: leg A high) |
| en_n | input | N_CH | Active-low enable per channel |
| trip | input | N_CH | Current-trip comparator per channel (asynchronous) |
| gate_ah | output | N_CH | Leg A high-side gate enable |
| gate_al | output | N_CH | Leg A low-side gate enable |
| gate_bh | output | N_CH | Leg B high-side gate enable |
| gate_bl | output | N_CH | Leg B low-side gate enable |

## Verification
A cycle timer that counts wrongly shows up within one period. The interval between source turn-ons moves away from the period, or the gap between the two channels moves away from half a period. A source latch that is stuck or cleared too early shows up in the same cycle. Either the slow-decay pattern never appears after a trip, or a held trip suppresses the on-pulse completely. The bench also catches a pulse that outlives the blanking window, and a source that reappears after a fault before the next cycle start. A dead-time counter that miscounts is caught at the very next leg transition, because the bench tracks how long the opposite gate has been off.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      LEG_IDLE = 2'd0,
      LEG_HIGH = 2'd1,
      LEG_LOW  = 2'd2
   } leg_own_e;

   typedef struct packed {
      logic ah;
      logic al;
      logic bh;
      logic bl;
   } gate_req_t;

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int PERIOD = 32,
   parameter int N_CH   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [N_CH-1:0] start_o
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   if (PERIOD < 2 * N_CH) begin : g_chk_period
      $error("chop_timer: PERIOD too short for channel offsets");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_start
      localparam int OFFS = (i * PERIOD) / N_CH;
      assign start_o[i] = (cnt_q == CW'(OFFS));
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LAST) |=> (cnt_q == '0)); // R4
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_o)); // R5

endmodule

// File: rtl/chop_channel.sv
module chop_channel
   import chop_pkg::*;
#(
   parameter int BLANK_CYC   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      fault_i,
   input  logic      sleep_n_i,
   input  logic      en_n_i,
   input  logic      phase_i,
   input  logic      trip_i,
   output gate_req_t want_o
);
   localparam int BW = (BLANK_CYC > 0) ? $clog2(BLANK_CYC + 1) : 1;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("chop_channel: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   trip_s;
   logic                   blank_done;
   logic                   src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], trip_i};
   end
   assign trip_s = sync_q[SYNC_STAGES-1];

   if (BLANK_CYC > 0) begin : g_blank
      logic [BW-1:0] blank_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              blank_q <= '0;
         else if (start_i)        blank_q <= BW'(BLANK_CYC);
         else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
      end
      assign blank_done = (blank_q == '0);
   end else begin : g_noblank
      assign blank_done = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    src_q <= 1'b0;
      else if (fault_i)              src_q <= 1'b0;
      else if (start_i)              src_q <= 1'b1;
      else if (blank_done && trip_s) src_q <= 1'b0;
   end

   always_comb begin
      want_o = '0;
      if (sleep_n_i && !fault_i && !en_n_i) begin
         if (src_q) begin
            if (phase_i) begin
               want_o.ah = 1'b1;
               want_o.bl = 1'b1;
            end else begin
               want_o.bh = 1'b1;
               want_o.al = 1'b1;
            end
         end else begin
            want_o.al = 1'b1;
            want_o.bl = 1'b1;
         end
      end
   end

   AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q && !blank_done && !fault_i) |=> src_q); // R3
   AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> !src_q); // R9

endmodule

// File: rtl/chop_deadtime.sv
module chop_deadtime
   import chop_pkg::*;
#(
   parameter int DEAD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want_h_i,
   input  logic want_l_i,
   output logic gate_h_o,
   output logic gate_l_o
);
   localparam int DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;

   leg_own_e own_q, own_d;
   logic     gap_ok;

   if (DEAD_CYC > 0) begin : g_gap
      logic [DW-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        gap_q <= '0;
         else if (own_q != LEG_IDLE)        gap_q <= '0;
         else if (gap_q != DW'(DEAD_CYC))   gap_q <= gap_q + 1'b1;
      end
      assign gap_ok = (gap_q == DW'(DEAD_CYC));
   end else begin : g_nogap
      assign gap_ok = 1'b1;
   end

   always_comb begin
      own_d = own_q;
      case (own_q)
         LEG_HIGH: if (!want_h_i) own_d = LEG_IDLE;
         LEG_LOW:  if (!want_l_i) own_d = LEG_IDLE;
         default: begin
            if (gap_ok && want_h_i)      own_d = LEG_HIGH;
            else if (gap_ok && want_l_i) own_d = LEG_LOW;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= LEG_IDLE;
      else        own_q <= own_d;
   end

   assign gate_h_o = (own_q == LEG_HIGH) && want_h_i;
   assign gate_l_o = (own_q == LEG_LOW)  && want_l_i;

   AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_h_o && gate_l_o)); // R8
   AST_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_h_o) |-> !$past(gate_l_o)); // R8
   AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_l_o) |-> !$past(gate_h_o)); // R8

endmodule

// File: rtl/dual_chopper.sv
module dual_chopper
   import chop_pkg::*;
#(
   parameter int N_CH         = 2,
   parameter int OVERHEAD_CYC = 6,
   parameter int BLANK_CYC    = 8,
   parameter int RC_CYC       = 18,
   parameter int DEAD_CYC     = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_n,
   input  logic            fault,
   input  logic [N_CH-1:0] phase,
   input  logic [N_CH-1:0] en_n,
   input  logic [N_CH-1:0] trip,
   output logic [N_CH-1:0] gate_ah,
   output logic [N_CH-1:0] gate_al,
   output logic [N_CH-1:0] gate_bh,
   output logic [N_CH-1:0] gate_bl
);
   localparam int PERIOD = OVERHEAD_CYC + BLANK_CYC + RC_CYC;

   if (N_CH < 1) begin : g_chk_nch
      $error("dual_chopper: N_CH must be positive");
   end
   if (OVERHEAD_CYC < 1 || BLANK_CYC < 0 || RC_CYC < 0 || DEAD_CYC < 0) begin : g_chk_times
      $error("dual_chopper: invalid timing parameters");
   end

   logic [N_CH-1:0] start;

   chop_timer #(.PERIOD(PERIOD), .N_CH(N_CH)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_o (start)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      gate_req_t want;

      chop_channel #(.BLANK_CYC(BLANK_CYC), .SYNC_STAGES(SYNC_STAGES)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_i   (start[c]),
         .fault_i   (fault),
         .sleep_n_i (sleep_n),
         .en_n_i    (en_n[c]),
         .phase_i   (phase[c]),
         .trip_i    (trip[c]),
         .want_o    (want)
      );

      chop_deadtime #(.DEAD_CYC(DEAD_CYC)) leg_a_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .want_h_i (want.ah),
         .want_l_i (want.al),
         .gate_h_o (gate_ah[c]),
         .gate_l_o (gate_al[c])
      );

      chop_deadtime #(.DEAD_CYC(DEAD_CYC)) leg_b_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .want_h_i (want.bh),
         .want_l_i (want.bl),
         .gate_h_o (gate_bh[c]),
         .gate_l_o (gate_bl[c])
      );

      AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         en_n[c] |-> !(gate_ah[c] || gate_al[c] || gate_bh[c] || gate_bl[c])); // R7
   end

   AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |-> ((gate_ah | gate_al | gate_bh | gate_bl) == '0)); // R6
   AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ((gate_ah | gate_al | gate_bh | gate_bl) == '0)); // R9

endmodule

// File: tb/dual_chopper_tb_top.sv
`timescale 1ns/100ps
module dual_chopper_tb_top;
   localparam int N_CH     = 2;
   localparam int OVH      = 6;
   localparam int BLANK    = 8;
   localparam int RC       = 18;
   localparam int DEAD     = 2;
   localparam int PERIOD   = OVH + BLANK + RC;
   localparam int WD_LIMIT = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1;
   logic fault = 1'b0;
   logic [N_CH-1:0] phase = '1;
   logic [N_CH-1:0] en_n = '0;
   logic [N_CH-1:0] trip = '0;
   logic [N_CH-1:0] gate_ah, gate_al, gate_bh, gate_bl;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit meas_on = 1'b0;
   bit have0 = 1'b0;
   int last0 = 0;
   int rises0 = 0;
   bit done = 1'b0;

   logic [3:0] prev_h = '0, prev_l = '0;
   int h_off [4] = '{255, 255, 255, 255};
   int l_off [4] = '{255, 255, 255, 255};

   always #2.5 clk = ~clk;

   dual_chopper #(.N_CH(N_CH), .OVERHEAD_CYC(OVH), .BLANK_CYC(BLANK),
                  .RC_CYC(RC), .DEAD_CYC(DEAD), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fault(fault),
      .phase(phase), .en_n(en_n), .trip(trip),
      .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
   );

   function automatic logic [3:0] exp_drive(logic ph);
      return ph ? 4'b1001 : 4'b0110;   // {ah, al, bh, bl}
   endfunction

   function automatic logic [3:0] exp_decay();
      return 4'b0101;
   endfunction

   function automatic logic [3:0] ch_gates(int c);
      return {gate_ah[c], gate_al[c], gate_bh[c], gate_bl[c]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // continuous monitor, sampled away from the clock edge
   always @(negedge clk) begin
      #1;
      cyc++;
      if (!rst_n) begin
         check("R10 reset off", {gate_ah, gate_al, gate_bh, gate_bl}, 0);
      end else begin
         for (int c = 0; c < N_CH; c++) begin
            if (!sleep_n)     check("R6 sleep off", ch_gates(c), 0);
            else if (fault)   check("R9 fault off", ch_gates(c), 0);
            else if (en_n[c]) check("R7 enable off", ch_gates(c), 0);
         end
         for (int l = 0; l < 4; l++) begin
            logic h, lo;
            h  = (l[0] == 1'b0) ? gate_ah[l/2] : gate_bh[l/2];
            lo = (l[0] == 1'b0) ? gate_al[l/2] : gate_bl[l/2];
            check("R8 exclusive", {31'd0, h & lo}, 0);
            if (h && !prev_h[l])  check("R8 gap before high", {31'd0, l_off[l] >= DEAD}, 1);
            if (lo && !prev_l[l]) check("R8 gap before low",  {31'd0, h_off[l] >= DEAD}, 1);
            h_off[l] = h  ? 0 : h_off[l] + 1;
            l_off[l] = lo ? 0 : l_off[l] + 1;
            prev_h[l] = h;
            prev_l[l] = lo;
         end
         if (meas_on) begin
            if (gate_ah[0] && !prev_ah0) begin
               if (have0) check("R4 period", cyc - last0, PERIOD);
               last0 = cyc;
               have0 = 1'b1;
               rises0++;
            end
            if (!gate_ah[0] && prev_ah0 && have0)
               check("R3 pulse width", {31'd0, (cyc - last0) <= BLANK + 1}, 1);
            if (gate_ah[1] && !prev_ah1 && have0)
               check("R5 channel offset", cyc - last0, PERIOD / 2);
         end
         prev_ah0 = gate_ah[0];
         prev_ah1 = gate_ah[1];
      end
   end
   logic prev_ah0 = 1'b0, prev_ah1 = 1'b0;

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(WD_LIMIT * 5.0);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd41));
      wait_cyc(4);
      #1;
      check("R10 reset state", {gate_ah, gate_al, gate_bh, gate_bl}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 directed forward drive, phase 1 on both
      wait_cyc(2 * PERIOD + 10);
      #1;
      for (int c = 0; c < N_CH; c++) check("R1 forward", ch_gates(c), exp_drive(1'b1));

      // R1 / R7 random phase and enable patterns
      for (int it = 0; it < 10; it++) begin
         @(negedge clk);
         phase = N_CH'($urandom);
         en_n  = N_CH'($urandom);
         wait_cyc(2 * PERIOD);
         #1;
         for (int c = 0; c < N_CH; c++)
            check(en_n[c] ? "R7 disabled" : "R1 drive", ch_gates(c),
                  en_n[c] ? 4'b0000 : exp_drive(phase[c]));
      end

      // R3 / R4 / R5 measurement with trip held high
      @(negedge clk);
      en_n = '0; phase = '1; trip = '1;
      wait_cyc(2 * PERIOD);
      meas_on = 1'b1;
      wait_cyc(6 * PERIOD);
      meas_on = 1'b0;
      check("R3 source turns on each cycle", {31'd0, rises0 >= 5}, 1);

      // R2 slow decay after trip, both phases
      for (int p = 1; p >= 0; p--) begin
         @(negedge clk);
         phase = p[0] ? '1 : '0;
         wait_cyc(2 * PERIOD);
         for (int c = 0; c < N_CH; c++) begin
            if (p == 1) @(negedge gate_ah[c]);
            else        @(negedge gate_bh[c]);
            wait_cyc(DEAD + 3);
            #1;
            check("R2 slow decay", ch_gates(c), exp_decay());
         end
      end

      // R9 fault then resume only at next cycle start
      @(negedge clk);
      phase = '1;
      wait_cyc(2 * PERIOD);
      @(posedge gate_ah[0]);
      @(negedge clk);
      fault = 1'b1;
      trip  = '0;
      @(negedge clk);
      fault = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         #1;
         check("R9 no source before cycle start", {31'd0, gate_ah[0]}, 0);
      end
      wait_cyc(12);
      #1;
      check("R9 resumes at cycle start", {31'd0, gate_ah[0]}, 1);

      // R6 sleep with random phase, then recovery
      @(negedge clk);
      phase = N_CH'($urandom);
      wait_cyc(2 * PERIOD);
      @(negedge clk);
      sleep_n = 1'b0;
      #1;
      check("R6 sleep immediate", {gate_ah, gate_al, gate_bh, gate_bl}, 0);
      wait_cyc(PERIOD);
      #1;
      check("R6 sleep held", {gate_ah, gate_al, gate_bh, gate_bl}, 0);
      @(negedge clk);
      sleep_n = 1'b1;
      wait_cyc(2 * PERIOD);
      #1;
      for (int c = 0; c < N_CH; c++) check("R1 after sleep", ch_gates(c), exp_drive(phase[c]));

      done = 1'b1;
      summary();
   end

endmodule